// File: doc/BRIEF.md
# I2C Bit-Level Master Engine with Bus Recovery

This block is the bit engine beneath an I2C master controller. A transaction-level sequencer hands it one command at a time: generate a START condition, generate a STOP condition, shift out one byte and collect the slave's acknowledge, shift in one byte and answer it with a given acknowledge level, or run a bus-recovery sequence. The engine produces the SCL waveform, controls SDA as an open-drain line (it can only pull low or let go), and samples the SDA level seen on the bus.

All waveform timing is built from a quarter of the I2C bit period. A parameter gives the quarter length in system clocks; the default of 625 clocks gives a 5 µs quarter at 125 MHz. Every command is a fixed list of quarters. At the start of each quarter the engine may set SCL, set SDA, or leave both alone. SDA may be sampled at the end of a quarter. When the final quarter closes, a one-cycle done pulse is raised and the engine becomes ready again.

Bus recovery releases both lines and then clocks SCL nine times with SDA released. This lets a slave that is stuck mid-byte shift out its remaining bits. A normal STOP condition follows.

Top module: `i2c_bit_engine`

## Requirements
- R1: While reset is held and on the first cycle after it, SCL is high, SDA is released (sda_oe low), cmd_ready is high, done is low, rx_byte is 0x00 and rx_nack is 0.
- R2: A command is taken on a rising edge where cmd_valid and cmd_ready are both high. cmd_ready is low from the next cycle until done. done is a single-cycle pulse raised by the edge that closes the last quarter, and cmd_ready returns high in that same cycle. cmd_valid presented while the engine is busy has no effect on the lines or on the results.
- R3: Opcodes are START=0, STOP=1, WRITE=2, READ=3, RECOVER=4. The line values change only on the accept edge or on an edge that is a whole multiple of QUARTER_CYCLES edges after it. Quarter 0 starts at the accept edge.
- R4: START takes 4 quarters. Quarter 0 keeps both lines as they were. Quarter 1 releases SDA. Quarter 2 raises SCL. Quarter 3 pulls SDA low.
- R5: STOP takes 4 quarters, in this order: SCL low, then SDA low, then SCL high, then SDA released.
- R6: WRITE sends cmd_data most significant bit first, 4 quarters per bit. The quarters are: SCL low, SDA set to the bit (1 = released), SCL high, hold.
- R7: After the 8 data bits, WRITE adds 5 quarters: SCL low, SDA released, SCL high, hold, SCL low. At the end of the hold quarter the SDA level is sampled into rx_nack (1 = NACK, 0 = ACK).
- R8: READ takes 3 quarters per bit for 8 bits. The quarters are: SCL low with SDA released, SCL high, hold. SDA is sampled at the end of the SCL-high quarter and shifted into rx_byte most significant bit first.
- R9: After the 8 bits, READ adds 5 quarters: SCL low, SDA set to cmd_ack (0 = ACK driven low, 1 = NACK released), SCL high, hold, SCL low.
- R10: RECOVER takes 41 quarters. One quarter has both lines released high. Then come 9 clocks with SDA released, each made of SCL low, hold, SCL high, hold. Then the 4 STOP quarters follow, leaving SDA released.
- R11: Opcodes 5 to 7 are accepted and complete after one quarter without changing either line or either result.
- R12: rx_byte changes only during READ and rx_nack changes only during WRITE; both are valid when done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 3 | Command opcode |
| cmd_data | input | 8 | Byte to send for WRITE |
| cmd_ack | input | 1 | Acknowledge level to send after READ |
| done | output | 1 | One-cycle pulse when a command completes |
| rx_byte | output | 8 | Byte collected by the last READ |
| rx_nack | output | 1 | Acknowledge level sampled by the last WRITE |
| scl_o | output | 1 | SCL level driven to the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | SDA level observed on the bus |

## Verification
Each command is a known number of quarters N. Line values for quarter k are due from the edge k*QUARTER_CYCLES after the accept edge. done, cmd_ready and the result fields are due at edge N*QUARTER_CYCLES. The bench builds the expected per-quarter line list for each command behaviourally and compares scl_o, sda_oe, done and cmd_ready on every falling edge, half a cycle away from the updates. It checks done and the results on the falling edge just after the closing edge. The slave's SDA response is also placed per quarter, ahead of the sampling edge, so that each sample point is tested at its exact quarter.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    localparam int STEP_W = 6;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_STOP    = 3'd1,
        OP_WRITE   = 3'd2,
        OP_READ    = 3'd3,
        OP_RECOVER = 3'd4
    } op_e;

    typedef enum logic { ST_IDLE = 1'b0, ST_BUSY = 1'b1 } eng_st_e;

    // What happens at the start of a quarter, and what at its end.
    typedef struct packed {
        logic scl_en;
        logic scl_v;
        logic sda_en;
        logic sda_v;   // 1 = released
        logic smp;     // sample SDA when this quarter closes
        logic last;    // command finishes when this quarter closes
    } act_t;

    function automatic act_t stop_quarter(input logic [1:0] q);
        act_t a;
        a = '0;
        case (q)
            2'd0: begin a.scl_en = 1'b1; a.scl_v = 1'b0; end
            2'd1: begin a.sda_en = 1'b1; a.sda_v = 1'b0; end
            2'd2: begin a.scl_en = 1'b1; a.scl_v = 1'b1; end
            default: begin a.sda_en = 1'b1; a.sda_v = 1'b1; a.last = 1'b1; end
        endcase
        return a;
    endfunction

    function automatic act_t step_act(input logic [2:0] op, input logic [STEP_W-1:0] s,
                                      input logic [7:0] d, input logic ack);
        act_t a;
        logic [STEP_W-1:0] r;
        logic [STEP_W-1:0] t;
        a = '0;
        r = '0;
        t = '0;
        case (op)
            OP_START: begin
                case (s[1:0])
                    2'd1: begin a.sda_en = 1'b1; a.sda_v = 1'b1; end
                    2'd2: begin a.scl_en = 1'b1; a.scl_v = 1'b1; end
                    2'd3: begin a.sda_en = 1'b1; a.sda_v = 1'b0; a.last = 1'b1; end
                    default: ;
                endcase
            end
            OP_STOP: a = stop_quarter(s[1:0]);
            OP_WRITE: begin
                if (s < 6'd32) begin
                    case (s[1:0])
                        2'd0: begin a.scl_en = 1'b1; a.scl_v = 1'b0; end
                        2'd1: begin a.sda_en = 1'b1; a.sda_v = d[3'd7 - s[4:2]]; end
                        2'd2: begin a.scl_en = 1'b1; a.scl_v = 1'b1; end
                        default: ;
                    endcase
                end else begin
                    case (s)
                        6'd32: begin a.scl_en = 1'b1; a.scl_v = 1'b0; end
                        6'd33: begin a.sda_en = 1'b1; a.sda_v = 1'b1; end
                        6'd34: begin a.scl_en = 1'b1; a.scl_v = 1'b1; end
                        6'd35: a.smp = 1'b1;
                        default: begin a.scl_en = 1'b1; a.scl_v = 1'b0; a.last = 1'b1; end
                    endcase
                end
            end
            OP_READ: begin
                if (s < 6'd24) begin
                    r = s / 6'd3;
                    t = s - r * 6'd3;
                    case (t[1:0])
                        2'd0: begin
                            a.scl_en = 1'b1; a.scl_v = 1'b0;
                            a.sda_en = 1'b1; a.sda_v = 1'b1;
                        end
                        2'd1: begin a.scl_en = 1'b1; a.scl_v = 1'b1; a.smp = 1'b1; end
                        default: ;
                    endcase
                end else begin
                    case (s)
                        6'd24: begin a.scl_en = 1'b1; a.scl_v = 1'b0; end
                        6'd25: begin a.sda_en = 1'b1; a.sda_v = ack; end
                        6'd26: begin a.scl_en = 1'b1; a.scl_v = 1'b1; end
                        6'd27: ;
                        default: begin a.scl_en = 1'b1; a.scl_v = 1'b0; a.last = 1'b1; end
                    endcase
                end
            end
            OP_RECOVER: begin
                if (s == 6'd0) begin
                    a.scl_en = 1'b1; a.scl_v = 1'b1;
                    a.sda_en = 1'b1; a.sda_v = 1'b1;
                end else if (s <= 6'd36) begin
                    t = s - 6'd1;
                    if (t[1:0] == 2'd0) begin a.scl_en = 1'b1; a.scl_v = 1'b0; end
                    if (t[1:0] == 2'd2) begin a.scl_en = 1'b1; a.scl_v = 1'b1; end
                end else begin
                    t = s - 6'd37;
                    a = stop_quarter(t[1:0]);
                end
            end
            default: a.last = 1'b1;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/i2cb_qtimer.sv
module i2cb_qtimer #(
    parameter int QUARTER_CYCLES = 625
) (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    output logic tick
);
    localparam int CW = (QUARTER_CYCLES > 1) ? $clog2(QUARTER_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(QUARTER_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy || cnt == LAST) cnt <= '0;
        else                             cnt <= cnt + 1'b1;
    end

    assign tick = busy && (cnt == LAST);

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
endmodule

// File: rtl/i2cb_seq.sv
module i2cb_seq
    import i2cb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic [7:0] cmd_data,
    input  logic       cmd_ack,
    input  logic       tick,
    output logic       cmd_ready,
    output logic       busy,
    output logic       done,
    output logic       smp,
    output logic [2:0] op_o,
    output logic       scl_o,
    output logic       sda_oe
);
    eng_st_e           st;
    logic [STEP_W-1:0] step;
    logic [2:0]        op_q;
    logic [7:0]        dat_q;
    logic              ack_q;
    logic              scl_q;
    logic              sda_q;
    logic              done_q;
    logic              accept;
    act_t              cur, nxt, first;

    assign busy      = (st == ST_BUSY);
    assign cmd_ready = (st == ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;

    always_comb begin
        first = step_act(cmd_op, '0, cmd_data, cmd_ack);
        cur   = step_act(op_q, step, dat_q, ack_q);
        nxt   = step_act(op_q, STEP_W'(step + 1'b1), dat_q, ack_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            step   <= '0;
            op_q   <= '0;
            dat_q  <= '0;
            ack_q  <= 1'b1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                st    <= ST_BUSY;
                step  <= '0;
                op_q  <= cmd_op;
                dat_q <= cmd_data;
                ack_q <= cmd_ack;
                if (first.scl_en) scl_q <= first.scl_v;
                if (first.sda_en) sda_q <= first.sda_v;
            end else if (busy && tick) begin
                if (cur.last) begin
                    st     <= ST_IDLE;
                    done_q <= 1'b1;
                end else begin
                    step <= STEP_W'(step + 1'b1);
                    if (nxt.scl_en) scl_q <= nxt.scl_v;
                    if (nxt.sda_en) sda_q <= nxt.sda_v;
                end
            end
        end
    end

    assign smp    = busy && tick && cur.smp;
    assign op_o   = op_q;
    assign done   = done_q;
    assign scl_o  = scl_q;
    assign sda_oe = ~sda_q;

    // R3
    grid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !tick |=> $stable(scl_o) && $stable(sda_oe));
    // R2
    busy_lock_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready |=> !cmd_ready);
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_ready && !cmd_valid |=> $stable(scl_o) && $stable(sda_oe));
    // R6, R8
    byte_sda_chk: assert property (@(posedge clk) disable iff (rst)
        busy && (op_q == OP_WRITE || op_q == OP_READ) && scl_o && $past(scl_o)
        |-> $stable(sda_oe));
endmodule

// File: rtl/i2cb_rx.sv
module i2cb_rx
    import i2cb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       smp,
    input  logic [2:0] op,
    input  logic       sda_i,
    output logic [7:0] rx_byte,
    output logic       rx_nack
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_byte <= '0;
            rx_nack <= 1'b0;
        end else if (smp) begin
            if (op == OP_READ)  rx_byte <= {rx_byte[6:0], sda_i};
            if (op == OP_WRITE) rx_nack <= sda_i;
        end
    end

    // R12
    smp_kind_chk: assert property (@(posedge clk) disable iff (rst)
        smp |-> (op == OP_READ || op == OP_WRITE));
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine #(
    parameter int QUARTER_CYCLES = 625
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [2:0] cmd_op,
    input  logic [7:0] cmd_data,
    input  logic       cmd_ack,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       rx_nack,
    output logic       scl_o,
    output logic       sda_oe,
    input  logic       sda_i
);
    logic       busy;
    logic       tick;
    logic       smp;
    logic [2:0] op_cur;

    i2cb_qtimer #(.QUARTER_CYCLES(QUARTER_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .busy (busy),
        .tick (tick)
    );

    i2cb_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_data  (cmd_data),
        .cmd_ack   (cmd_ack),
        .tick      (tick),
        .cmd_ready (cmd_ready),
        .busy      (busy),
        .done      (done),
        .smp       (smp),
        .op_o      (op_cur),
        .scl_o     (scl_o),
        .sda_oe    (sda_oe)
    );

    i2cb_rx u_rx (
        .clk     (clk),
        .rst     (rst),
        .smp     (smp),
        .op      (op_cur),
        .sda_i   (sda_i),
        .rx_byte (rx_byte),
        .rx_nack (rx_nack)
    );
endmodule

// File: tb/i2c_bit_engine_test.sv
module i2c_bit_engine_test;
    localparam int QC = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] cmd_data = 8'd0;
    logic       cmd_ack = 1'b0;
    logic       done;
    logic [7:0] rx_byte;
    logic       rx_nack;
    logic       scl_o;
    logic       sda_oe;
    logic       slave_low = 1'b0;
    logic       sda_bus;

    assign sda_bus = ~(sda_oe | slave_low);

    always #4 clk = ~clk;

    i2c_bit_engine #(.QUARTER_CYCLES(QC)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_ack(cmd_ack), .done(done),
        .rx_byte(rx_byte), .rx_nack(rx_nack), .scl_o(scl_o), .sda_oe(sda_oe),
        .sda_i(sda_bus)
    );

    int   n_vec = 0;
    int   n_bad = 0;
    int   cyc = 0;
    int   mscl = 1;
    int   msda = 1;
    int   expq[$];
    bit   slvq[$];
    logic [7:0] exp_byte = 8'h00;
    logic       exp_nack = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_vec++;
            n_bad++;
            $display("FAIL R2 watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // One quarter: -1 keeps a line, 0/1 sets it (SDA 1 = released)
    task automatic q(input int s, input int d, input bit sl);
        if (s >= 0) mscl = s;
        if (d >= 0) msda = d;
        expq.push_back(mscl * 2 + msda);
        slvq.push_back(sl);
    endtask

    task automatic model_start();
        q(-1, -1, 0); q(-1, 1, 0); q(1, -1, 0); q(-1, 0, 0);
    endtask

    task automatic model_stop();
        q(0, -1, 0); q(-1, 0, 0); q(1, -1, 0); q(-1, 1, 0);
    endtask

    task automatic model_write(input logic [7:0] b, input bit nack);
        for (int i = 7; i >= 0; i--) begin
            q(0, -1, !nack); q(-1, int'(b[i]), !nack); q(1, -1, !nack); q(-1, -1, !nack);
        end
        q(0, -1, !nack); q(-1, 1, !nack); q(1, -1, !nack); q(-1, -1, !nack); q(0, -1, !nack);
        exp_nack = nack;
    endtask

    task automatic model_read(input logic [7:0] b, input bit ack);
        for (int i = 7; i >= 0; i--) begin
            q(0, 1, !b[i]); q(1, -1, !b[i]); q(-1, -1, !b[i]);
        end
        q(0, -1, 0); q(-1, int'(ack), 0); q(1, -1, 0); q(-1, -1, 0); q(0, -1, 0);
        exp_byte = b;
    endtask

    task automatic model_recover();
        q(1, 1, 0);
        for (int i = 0; i < 9; i++) begin
            q(0, -1, 0); q(-1, -1, 0); q(1, -1, 0); q(-1, -1, 0);
        end
        model_stop();
    endtask

    // Issue a command, compare lines every cycle, then the completion cycle.
    task automatic run_cmd(input logic [2:0] op, input logic [7:0] d, input bit ack,
                           input string tag, input bit noise);
        int e;
        int nq;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R2 ready before issue", int'(cmd_ready), 1);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_data  = d;
        cmd_ack   = ack;
        nq = expq.size();
        for (int k = 0; k < nq * QC; k++) begin
            @(negedge clk);
            if (noise) begin
                cmd_valid = 1'b1;
                cmd_op    = 3'd1;
                cmd_data  = ~d;
                cmd_ack   = ~ack;
            end else begin
                cmd_valid = 1'b0;
            end
            slave_low = slvq[k / QC];
            e = expq[k / QC];
            chk(scl_o == e[1] && sda_oe == !e[0] && !done && !cmd_ready,
                tag, int'(scl_o) * 8 + int'(sda_oe) * 4 + int'(done) * 2 + int'(cmd_ready),
                int'(e[1]) * 8 + int'(!e[0]) * 4);
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        slave_low = 1'b0;
        e = expq[nq - 1];
        chk(done == 1'b1 && cmd_ready == 1'b1, "R2 done pulse",
            int'(done) * 2 + int'(cmd_ready), 3);
        chk(scl_o == e[1] && sda_oe == !e[0], tag,
            int'(scl_o) * 2 + int'(sda_oe), int'(e[1]) * 2 + int'(!e[0]));
        chk(rx_byte == exp_byte, (op == 3'd3) ? "R8 rx_byte" : "R12 rx_byte kept",
            int'(rx_byte), int'(exp_byte));
        chk(rx_nack == exp_nack, (op == 3'd2) ? "R7 rx_nack" : "R12 rx_nack kept",
            int'(rx_nack), int'(exp_nack));
        @(negedge clk);
        chk(done == 1'b0, "R2 done one cycle", int'(done), 0);
        expq.delete();
        slvq.delete();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(scl_o == 1'b1, "R1 scl", int'(scl_o), 1);
        chk(sda_oe == 1'b0, "R1 sda_oe", int'(sda_oe), 0);
        chk(cmd_ready == 1'b1, "R1 ready", int'(cmd_ready), 1);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(rx_byte == 8'h00, "R1 rx_byte", int'(rx_byte), 0);
        chk(rx_nack == 1'b0, "R1 rx_nack", int'(rx_nack), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(scl_o == 1'b1 && sda_oe == 1'b0 && cmd_ready == 1'b1, "R1 after release",
            int'(scl_o) * 4 + int'(sda_oe) * 2 + int'(cmd_ready), 5);

        // R10: recovery
        model_recover();
        run_cmd(3'd4, 8'h00, 1'b0, "R3 R10 recover", 1'b0);
        // R4: start
        model_start();
        run_cmd(3'd0, 8'h00, 1'b0, "R3 R4 start", 1'b0);
        // R6 R7: write with ACK
        model_write(8'hA5, 1'b0);
        run_cmd(3'd2, 8'hA5, 1'b0, "R3 R6 write A5", 1'b0);
        // R7: write with NACK
        model_write(8'h3C, 1'b1);
        run_cmd(3'd2, 8'h3C, 1'b0, "R3 R7 write 3C nack", 1'b0);
        // R8 R9: read, answer ACK
        model_read(8'h96, 1'b0);
        run_cmd(3'd3, 8'h00, 1'b0, "R3 R8 R9 read 96 ack", 1'b0);
        // R2: read with NACK while cmd_valid is held busy (ignored)
        model_read(8'h5A, 1'b1);
        run_cmd(3'd3, 8'h00, 1'b1, "R2 R9 read 5A nack busy noise", 1'b1);
        // R11: undefined opcode
        q(-1, -1, 0);
        run_cmd(3'd6, 8'hFF, 1'b0, "R11 opcode 6", 1'b0);
        // R4: repeated start from SCL low
        model_start();
        run_cmd(3'd0, 8'h00, 1'b0, "R4 repeated start", 1'b0);
        // R6 R12: all-zero write keeps rx_byte
        model_write(8'h00, 1'b0);
        run_cmd(3'd2, 8'h00, 1'b1, "R6 R12 write 00", 1'b0);
        // R5: stop
        model_stop();
        run_cmd(3'd1, 8'h00, 1'b0, "R3 R5 stop", 1'b0);
        // R11: undefined opcode after stop
        q(-1, -1, 0);
        run_cmd(3'd7, 8'h12, 1'b1, "R11 opcode 7", 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule